// File: doc/BRIEF.md
# Processor Reset Pulse Generator

This block gathers every reason a processor should be held in reset and turns them into one reset pulse with a guaranteed minimum length. There are three reasons. The first is a supply that is below its trip level. The second is a manual reset request. The third is a timeout from an external watchdog. The supply condition arrives as two digital flags from outside comparators, one for each trip level. A tolerance select picks which flag counts.

The manual request is active low. It is sampled on a slow millisecond tick and only counts after several low samples in a row. This rejects contact bounce and short glitches. A hold counter is reloaded while any cause is present. The reset is released only after the counter has run down a full hold period with no cause present. The block drives an active-high reset, an active-low reset and a flag that reports the processor is out of reset.

Top module: `rstgen_supervisor`

## Requirements
- R1: While `arst_n` is low, and after it rises, `reset_out` is 1. It stays 1 until `HOLD_TICKS` ticks of `tick_1ms` have passed with no cause present.
- R2: With `tol_wide` = 0 only `uv_tight` causes reset. With `tol_wide` = 1 only `uv_loose` causes reset. The flag that is not selected has no effect on `reset_out`.
- R3: When the selected undervoltage flag rises, `reset_out` is 1 on the third rising clock edge after the change, with no debounce. The first two edges are spent in the synchronizer.
- R4: A low on `man_rst_n` that covers fewer than `DEB_TICKS` tick samples leaves `reset_out` at 0.
- R5: A low on `man_rst_n` that covers `DEB_TICKS` consecutive tick samples sets `reset_out` to 1. With the defaults this is 4 samples at the 1 ms tick.
- R6: After the last cause clears, `reset_out` stays 1 for `HOLD_TICKS` ticks, then falls on a tick edge. Any cause present during the hold reloads the count.
- R7: A one-cycle pulse on `wdog_expire` sets `reset_out` to 1 on the next rising clock edge.
- R8: `reset_out_n` and `released` are always the inverse of `reset_out`.
- R9: A high sample of `man_rst_n` on a tick restarts the debounce count, so two low runs split by a high sample never add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low system reset |
| tick_1ms | input | 1 | One-cycle enable, once per millisecond |
| uv_tight | input | 1 | Undervoltage flag at the higher trip point (asynchronous, high = low supply) |
| uv_loose | input | 1 | Undervoltage flag at the lower trip point (asynchronous, high = low supply) |
| tol_wide | input | 1 | 0 selects `uv_tight`, 1 selects `uv_loose` (asynchronous) |
| man_rst_n | input | 1 | Manual reset request, active low (asynchronous) |
| wdog_expire | input | 1 | Watchdog timeout pulse, synchronous to `clk` |
| reset_out | output | 1 | Processor reset, active high |
| reset_out_n | output | 1 | Processor reset, active low |
| released | output | 1 | 1 when the processor is out of reset |

## Verification
The bench builds the block with `HOLD_TICKS` = 12, `DEB_TICKS` = 4 and two synchronizer stages, and it drives the tick once every four clocks. A hold period then lasts about 48 clocks. This puts the power-up hold, every release after a cleared cause, and the split-press debounce case within a few hundred cycles. It also leaves room to test both tolerance settings against each flag. The three-edge undervoltage latency and the one-edge watchdog latency are checked at exact cycles. Release times are checked on either side of the tick phase uncertainty.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_DEB_TICKS   = 4;
  localparam int unsigned DEF_HOLD_TICKS  = 250;

  // Asynchronous inputs gathered for the synchronizer, man_n on top.
  typedef struct packed {
    logic man_n;
    logic tol_wide;
    logic uv_loose;
    logic uv_tight;
  } async_in_t;

  localparam int unsigned ASYNC_W = $bits(async_in_t);
  localparam logic [ASYNC_W-1:0] ASYNC_RST = {1'b1, 1'b0, 1'b0, 1'b0};
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

  initial begin
    a_stages_r3: assert (STAGES >= 2) else $error("synchronizer needs two stages");
  end
endmodule

// File: rtl/rstgen_debounce.sv
module rstgen_debounce #(
  parameter int unsigned DEB = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic pin_n_i,
  output logic pressed_o
);
  localparam int unsigned CW = $clog2(DEB + 1);
  localparam logic [CW-1:0] FULL = CW'(DEB);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          prs_q, prs_d;

  always_comb begin
    cnt_d = cnt_q;
    prs_d = prs_q;
    if (tick_i) begin
      if (!pin_n_i) begin
        if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
        prs_d = (cnt_d == FULL);
      end else begin
        cnt_d = '0;
        prs_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      prs_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      prs_q <= prs_d;
    end
  end

  assign pressed_o = prs_q;

  // R5: a press is recognised only on a tick that sampled the pin low.
  p_press_on_low_tick_r5: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(prs_q) |-> ($past(tick_i) && !$past(pin_n_i)));

  // R9: a high sample ends the press and restarts the count.
  p_high_restarts_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (tick_i && pin_n_i) |=> (!prs_q && cnt_q == '0));
endmodule

// File: rtl/rstgen_hold.sv
module rstgen_hold #(
  parameter int unsigned HOLD = 250
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic cause_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cause_i)                     cnt_d = LOAD;
    else if (tick_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    rst_d = cause_i | (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= LOAD;
      rst_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign rst_o = rst_q;

  // R6: release happens only on a tick edge with no cause present.
  p_release_on_tick_r6: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_q) |-> ($past(tick_i) && !$past(cause_i)));

  // R6: an active cause keeps reset asserted on the next edge.
  p_cause_holds_r6: assert property (@(posedge clk) disable iff (!arst_n)
    cause_i |=> rst_q);

  // R6: the hold count never exceeds its load value.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= LOAD);
endmodule

// File: rtl/rstgen_supervisor.sv
module rstgen_supervisor
  import rstgen_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned DEB_TICKS   = DEF_DEB_TICKS,
  parameter int unsigned HOLD_TICKS  = DEF_HOLD_TICKS
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_1ms,
  input  logic uv_tight,
  input  logic uv_loose,
  input  logic tol_wide,
  input  logic man_rst_n,
  input  logic wdog_expire,
  output logic reset_out,
  output logic reset_out_n,
  output logic released
);
  async_in_t raw_in, syn_in;
  logic      uv_sel, man_pressed, cause, rst_int;

  always_comb begin
    raw_in.man_n    = man_rst_n;
    raw_in.tol_wide = tol_wide;
    raw_in.uv_loose = uv_loose;
    raw_in.uv_tight = uv_tight;
  end

  rstgen_sync #(
    .W(ASYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(ASYNC_RST)
  ) u_sync (
    .clk(clk), .arst_n(arst_n), .din(raw_in), .dout(syn_in)
  );

  rstgen_debounce #(.DEB(DEB_TICKS)) u_deb (
    .clk(clk), .arst_n(arst_n), .tick_i(tick_1ms),
    .pin_n_i(syn_in.man_n), .pressed_o(man_pressed)
  );

  // Tolerance select: 0 picks the higher trip point, 1 the lower one.
  always_comb begin
    uv_sel = syn_in.tol_wide ? syn_in.uv_loose : syn_in.uv_tight;
    cause  = uv_sel | man_pressed | wdog_expire;
  end

  rstgen_hold #(.HOLD(HOLD_TICKS)) u_hold (
    .clk(clk), .arst_n(arst_n), .tick_i(tick_1ms),
    .cause_i(cause), .rst_o(rst_int)
  );

  assign reset_out   = rst_int;
  assign reset_out_n = ~rst_int;
  assign released    = ~rst_int;

  // R2: the tight flag acts only with tol_wide = 0.
  p_tight_selected_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (!syn_in.tol_wide && syn_in.uv_tight) |=> reset_out);

  // R3: the synchronised undervoltage flag asserts reset on the next edge.
  p_uv_immediate_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (syn_in.tol_wide && syn_in.uv_loose) |=> reset_out);

  // R7: a watchdog pulse asserts reset on the next edge.
  p_wdog_asserts_r7: assert property (@(posedge clk) disable iff (!arst_n)
    wdog_expire |=> reset_out);
endmodule

// File: tb/rstgen_supervisor_test.sv
module rstgen_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;
  localparam int DEB  = 4;
  localparam int WATCHDOG_CYC = 20000;

  logic clk = 1'b0;
  logic arst_n, tick_1ms, uv_tight, uv_loose, tol_wide, man_rst_n, wdog_expire;
  logic reset_out, reset_out_n, released;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    exp;
    string tag;
  } exp_item_t;
  exp_item_t sb[$];

  rstgen_supervisor #(
    .SYNC_STAGES(2), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD)
  ) uut (
    .clk(clk), .arst_n(arst_n), .tick_1ms(tick_1ms),
    .uv_tight(uv_tight), .uv_loose(uv_loose), .tol_wide(tol_wide),
    .man_rst_n(man_rst_n), .wdog_expire(wdog_expire),
    .reset_out(reset_out), .reset_out_n(reset_out_n), .released(released)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // Tick once every four clocks.
  always @(negedge clk) tick_1ms <= (cyc % 4 == 3);

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_at(int off, bit v, string tag);
    exp_item_t it;
    it.at = cyc + off; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_span(int from, int to, bit v, string tag);
    for (int k = from; k <= to; k += 3) expect_at(k, v, tag);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops every expected item due this cycle.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        check(reset_out == sb[i].exp, sb[i].tag, reset_out, sb[i].exp);
        check(reset_out_n == ~reset_out && released == ~reset_out, "R8",
              {reset_out_n, released}, {~reset_out, ~reset_out});
        sb.delete(i);
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc == WATCHDOG_CYC);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, got cycle %0d expected end before it", cyc);
      summary();
    end
  end

  initial begin
    arst_n = 1'b0; tick_1ms = 1'b0; uv_tight = 1'b0; uv_loose = 1'b0;
    tol_wide = 1'b0; man_rst_n = 1'b1; wdog_expire = 1'b0;
    wait_cyc(3);
    // R1: reset state
    check(reset_out == 1'b1, "R1", reset_out, 1);
    check(reset_out_n == 1'b0 && released == 1'b0, "R8", {reset_out_n, released}, 0);
    arst_n = 1'b1;
    // R1: power-up hold of HOLD ticks
    expect_at(40, 1'b1, "R1");
    expect_at(60, 1'b0, "R1");
    wait_cyc(64);

    // R2: unselected loose flag ignored with tol_wide = 0
    uv_loose = 1'b1;
    expect_span(1, 40, 1'b0, "R2");
    wait_cyc(41);
    uv_loose = 1'b0;
    wait_cyc(4);

    // R3: tight flag acts on the third edge
    uv_tight = 1'b1;
    expect_at(2, 1'b0, "R3");
    expect_at(3, 1'b1, "R3");
    wait_cyc(20);
    uv_tight = 1'b0;
    expect_at(44, 1'b1, "R6");
    expect_at(60, 1'b0, "R6");
    wait_cyc(64);

    // R2: tol_wide = 1 swaps the selected flag
    tol_wide = 1'b1;
    wait_cyc(6);
    uv_tight = 1'b1;
    expect_span(1, 40, 1'b0, "R2");
    wait_cyc(41);
    uv_tight = 1'b0;
    wait_cyc(4);
    uv_loose = 1'b1;
    expect_at(2, 1'b0, "R2");
    expect_at(3, 1'b1, "R2");
    wait_cyc(8);
    uv_loose = 1'b0;
    expect_at(44, 1'b1, "R6");
    expect_at(60, 1'b0, "R6");
    wait_cyc(64);

    // R4: short manual low, two tick samples only
    man_rst_n = 1'b0;
    expect_span(1, 30, 1'b0, "R4");
    wait_cyc(8);
    man_rst_n = 1'b1;
    wait_cyc(30);

    // R9: three lows, one high sample, three lows
    man_rst_n = 1'b0;
    expect_span(1, 40, 1'b0, "R9");
    wait_cyc(12);
    man_rst_n = 1'b1;
    wait_cyc(4);
    man_rst_n = 1'b0;
    wait_cyc(12);
    man_rst_n = 1'b1;
    wait_cyc(20);

    // R5: long manual low is recognised
    man_rst_n = 1'b0;
    expect_at(2, 1'b0, "R5");
    expect_at(22, 1'b1, "R5");
    wait_cyc(40);
    man_rst_n = 1'b1;
    expect_at(44, 1'b1, "R6");
    expect_at(64, 1'b0, "R6");
    wait_cyc(68);

    // R7: watchdog pulse
    wdog_expire = 1'b1;
    expect_at(0, 1'b0, "R7");
    expect_at(1, 1'b1, "R7");
    wait_cyc(1);
    wdog_expire = 1'b0;
    expect_at(39, 1'b1, "R6");
    expect_at(59, 1'b0, "R6");
    wait_cyc(64);

    check(sb.size() == 0, "R6", sb.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule